// File: doc/BRIEF.md
# Serial Control Register Port

This block is the host-facing control port of a three-colour image front end. A host talks to it over three wires: an active-low load strobe, a serial clock and one data line that both sides drive in turn. Each transfer selects one of eight 9-bit control registers and either writes it or reads it back. The registers are one operating-mode word, one channel-order and clamp word, three per-colour gain words and three per-colour offset words. The block decodes their fields and presents them as static outputs for the rest of the datapath.

All three serial wires are sampled in the system clock domain through a two-flop synchronizer and edge detectors. The serial clock must therefore stay well below the system clock. The shared data line is split into an input, an output and an output enable, and the pad cell combines them.

A frame is one flag bit, a 3-bit address and a 9-bit value, each sent most significant bit first. A write is applied only when the frame holds exactly thirteen serial clocks and the strobe is released. On a read, the block takes the line after the address and shifts out the stored word, including the bits that are meant to be zero.

Top module: `ser_reg_if`

## Requirements
- R1: After reset the words read back as follows: address 0 is 0x070, address 1 is 0x0CF, addresses 2 to 7 are 0. The exported fields match these words: clamp_int, three_ch and cds are 1; pwr_dn, range_2v and byte_out are 0; rgb_order is 1; single_sel is 3'b100; clamp_code is 4'hF; all gains and offsets are 0.
- R2: A frame starts when sload_ni falls and its bits are sampled on rising sclk_i edges while sload_ni is low. The bits are, in order, a flag (0 = write), A2..A0 and D8..D0. A write updates the addressed word when sload_ni rises.
- R3: Address map and field positions. Address 0 drives clamp_int from D6, three_ch from D5, cds from D4, pwr_dn from D2, range_2v from D1 and byte_out from D0. Address 1 drives rgb_order from D7, single_sel from {D6,D5,D4} (red, green, blue) and clamp_code from D3..D0. Addresses 2, 3 and 4 are the red, green and blue gains, and only D5..D0 are exported, into gain_o[5:0], [11:6] and [17:12]. Addresses 5, 6 and 7 are the red, green and blue offsets, exported as all 9 bits in sign-magnitude form with D8 as the sign, into offset_o[8:0], [17:9] and [26:18].
- R4: A frame with fewer or more than 13 rising sclk_i edges writes nothing.
- R5: On a read (flag = 1), sdata_oe_o rises after the 4th falling sclk_i edge and sdata_o presents D8. Each later falling edge presents the next lower bit. sdata_oe_o stays low outside this window and returns low when sload_ni rises.
- R6: A read returns all 9 stored bits as written, including bits the field map leaves unused.
- R7: A read frame changes no register or exported field.
- R8: Writing pwr_dn = 1 sets cfg_pwr_dn_o and leaves every other register unchanged.
- R9: sclk_i edges while sload_ni is high have no effect on the registers or on sdata_oe_o.
- R10: Exported fields take their new value on the 4th rising clk_i edge after sload_ni rises, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock |
| sload_ni | input | 1 | Frame strobe, active low |
| sdata_i | input | 1 | Serial data from the pad |
| sdata_o | output | 1 | Serial read data to the pad |
| sdata_oe_o | output | 1 | Pad driver enable for read data |
| cfg_clamp_int_o | output | 1 | Internal clamp reference select |
| cfg_three_ch_o | output | 1 | Three-channel mode |
| cfg_cds_o | output | 1 | Correlated double sampling enable |
| cfg_pwr_dn_o | output | 1 | Power-down request |
| cfg_range_2v_o | output | 1 | Large full-scale range select |
| cfg_byte_out_o | output | 1 | Single-byte output mode |
| mux_rgb_order_o | output | 1 | 1 = red first, 0 = blue first |
| mux_single_sel_o | output | 3 | Single-channel select {red, green, blue} |
| clamp_code_o | output | 4 | Clamp level code |
| gain_o | output | 18 | Gains, red in the low 6 bits |
| offset_o | output | 27 | Sign-magnitude offsets, red in the low 9 bits |

## Verification
The sload_ni and sclk_i edges pass through two synchronizer flops and an edge register. A committed write therefore reaches the exported fields on the 4th system clock edge after the strobe rises. A read bit appears on sdata_o on the 3rd edge after a falling sclk_i, and sdata_oe_o drops on the 3rd edge after the strobe rises. The bench changes inputs and samples outputs on falling system clock edges. It checks the write latency exactly at edges 3 and 4. It holds each serial clock phase for 8 system clocks, so read bits are sampled 5 clocks after they are due.

// File: rtl/sri_pkg.sv
package sri_pkg;
  localparam int REG_W     = 9;
  localparam int ADDR_W    = 3;
  localparam int NUM_REGS  = 2 ** ADDR_W;
  localparam int GAIN_W    = 6;
  localparam int NUM_COL   = 3;
  localparam int FRAME_LEN = 1 + ADDR_W + REG_W;

  localparam int A_CFG   = 0;
  localparam int A_MUX   = 1;
  localparam int A_GAIN0 = 2;
  localparam int A_OFS0  = 5;

  localparam int CFG_CLAMP = 6;
  localparam int CFG_3CH   = 5;
  localparam int CFG_CDS   = 4;
  localparam int CFG_PD    = 2;
  localparam int CFG_RANGE = 1;
  localparam int CFG_BYTE  = 0;
  localparam int MUX_ORDER = 7;
  localparam int MUX_SEL_H = 6;
  localparam int CLAMP_W   = 4;

  function automatic logic [REG_W-1:0] reset_value(input int idx);
    case (idx)
      A_CFG:   return 9'h070;
      A_MUX:   return 9'h0CF;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/sri_sync.sv
module sri_sync #(
  parameter int            W      = 3,
  parameter int            STAGES = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) pipe_q[s] <= RST_VAL;
    end else begin
      pipe_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/sri_edge.sv
module sri_edge #(
  parameter int           W       = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/sri_ctrl.sv
module sri_ctrl #(
  parameter int REG_W  = sri_pkg::REG_W,
  parameter int ADDR_W = sri_pkg::ADDR_W,
  localparam int FRAME_LEN = 1 + ADDR_W + REG_W,
  localparam int HDR_LEN   = 1 + ADDR_W,
  localparam int CNT_W     = $clog2(FRAME_LEN + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              sload_rise_i,
  input  logic              sload_fall_i,
  input  logic              sclk_rise_i,
  input  logic              sclk_fall_i,
  input  logic              sdata_i,
  input  logic [REG_W-1:0]  rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [REG_W-1:0]  wr_data_o,
  output logic              sdata_o,
  output logic              sdata_oe_o,
  output logic [CNT_W-1:0]  bit_cnt_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_LEN);

  logic [FRAME_LEN-1:0] shreg_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [REG_W-1:0]     rd_sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q    <= '0;
      cnt_q      <= '0;
      rd_sh_q    <= '0;
      wr_en_o    <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
      sdata_o    <= 1'b0;
      sdata_oe_o <= 1'b0;
    end else begin
      wr_en_o <= 1'b0;
      if (sload_fall_i) begin
        shreg_q    <= '0;
        cnt_q      <= '0;
        sdata_oe_o <= 1'b0;
      end else if (sload_rise_i) begin
        sdata_oe_o <= 1'b0;
        sdata_o    <= 1'b0;
        // commit only complete write frames
        if (cnt_q == CNT_FULL && !shreg_q[FRAME_LEN-1]) wr_en_o <= 1'b1;
        wr_addr_o <= shreg_q[REG_W +: ADDR_W];
        wr_data_o <= shreg_q[REG_W-1:0];
      end else if (active_i) begin
        if (sclk_rise_i) begin
          shreg_q <= {shreg_q[FRAME_LEN-2:0], sdata_i};
          if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        end
        if (sclk_fall_i) begin
          if (cnt_q == CNT_HDR && shreg_q[HDR_LEN-1]) begin
            sdata_oe_o <= 1'b1;
            sdata_o    <= rd_data_i[REG_W-1];
            rd_sh_q    <= {rd_data_i[REG_W-2:0], 1'b0};
          end else if (sdata_oe_o) begin
            sdata_o <= rd_sh_q[REG_W-1];
            rd_sh_q <= {rd_sh_q[REG_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign rd_addr_o = shreg_q[ADDR_W-1:0];
  assign bit_cnt_o = cnt_q;
endmodule

// File: rtl/sri_regs.sv
module sri_regs #(
  parameter int REG_W   = sri_pkg::REG_W,
  parameter int ADDR_W  = sri_pkg::ADDR_W,
  parameter int GAIN_W  = sri_pkg::GAIN_W,
  parameter int NUM_COL = sri_pkg::NUM_COL,
  localparam int NUM_REGS = 2 ** ADDR_W,
  localparam int CLAMP_W  = sri_pkg::CLAMP_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [REG_W-1:0]           wr_data_i,
  input  logic [ADDR_W-1:0]          rd_addr_i,
  output logic [REG_W-1:0]           rd_data_o,
  output logic [5:0]                 cfg_flags_o,
  output logic                       rgb_order_o,
  output logic [2:0]                 single_sel_o,
  output logic [CLAMP_W-1:0]         clamp_code_o,
  output logic [NUM_COL*GAIN_W-1:0]  gain_o,
  output logic [NUM_COL*REG_W-1:0]   offset_o
);
  import sri_pkg::*;

  logic [NUM_REGS-1:0][REG_W-1:0] mem;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [REG_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     q <= reset_value(g);
      else if (wr_en_i && wr_addr_i == ADDR_W'(g))     q <= wr_data_i;
    end
    assign mem[g] = q;
  end

  assign rd_data_o = mem[rd_addr_i];

  assign cfg_flags_o  = {mem[A_CFG][CFG_CLAMP], mem[A_CFG][CFG_3CH], mem[A_CFG][CFG_CDS],
                         mem[A_CFG][CFG_PD], mem[A_CFG][CFG_RANGE], mem[A_CFG][CFG_BYTE]};
  assign rgb_order_o  = mem[A_MUX][MUX_ORDER];
  assign single_sel_o = mem[A_MUX][MUX_SEL_H -: 3];
  assign clamp_code_o = mem[A_MUX][CLAMP_W-1:0];

  for (genvar c = 0; c < NUM_COL; c++) begin : g_col
    assign gain_o[c*GAIN_W +: GAIN_W] = mem[A_GAIN0 + c][GAIN_W-1:0];
    assign offset_o[c*REG_W +: REG_W] = mem[A_OFS0 + c];
  end
endmodule

// File: rtl/ser_reg_if.sv
module ser_reg_if #(
  parameter int REG_W       = sri_pkg::REG_W,
  parameter int ADDR_W      = sri_pkg::ADDR_W,
  parameter int GAIN_W      = sri_pkg::GAIN_W,
  parameter int NUM_COL     = sri_pkg::NUM_COL,
  parameter int SYNC_STAGES = 2,
  localparam int CLAMP_W    = sri_pkg::CLAMP_W,
  localparam int CNT_W      = $clog2(1 + ADDR_W + REG_W + 2)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      sclk_i,
  input  logic                      sload_ni,
  input  logic                      sdata_i,
  output logic                      sdata_o,
  output logic                      sdata_oe_o,
  output logic                      cfg_clamp_int_o,
  output logic                      cfg_three_ch_o,
  output logic                      cfg_cds_o,
  output logic                      cfg_pwr_dn_o,
  output logic                      cfg_range_2v_o,
  output logic                      cfg_byte_out_o,
  output logic                      mux_rgb_order_o,
  output logic [2:0]                mux_single_sel_o,
  output logic [CLAMP_W-1:0]        clamp_code_o,
  output logic [NUM_COL*GAIN_W-1:0] gain_o,
  output logic [NUM_COL*REG_W-1:0]  offset_o
);
  // bit 2: sclk, bit 1: sload, bit 0: sdata
  logic [2:0]        sync_lvl;
  logic [1:0]        rise, fall;
  logic              sload_lvl;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [REG_W-1:0]  wr_data, rd_data;
  logic [CNT_W-1:0]  bit_cnt;
  logic [5:0]        cfg_flags;

  sri_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk_i, .rst_ni,
    .d_i ({sclk_i, sload_ni, sdata_i}),
    .q_o (sync_lvl)
  );

  sri_edge #(.W(2), .RST_VAL(2'b01)) u_edge (
    .clk_i, .rst_ni,
    .lvl_i  (sync_lvl[2:1]),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign sload_lvl = sync_lvl[1];

  sri_ctrl #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk_i, .rst_ni,
    .active_i     (!sload_lvl),
    .sload_rise_i (rise[0]),
    .sload_fall_i (fall[0]),
    .sclk_rise_i  (rise[1]),
    .sclk_fall_i  (fall[1]),
    .sdata_i      (sync_lvl[0]),
    .rd_data_i    (rd_data),
    .rd_addr_o    (rd_addr),
    .wr_en_o      (wr_en),
    .wr_addr_o    (wr_addr),
    .wr_data_o    (wr_data),
    .sdata_o      (sdata_o),
    .sdata_oe_o   (sdata_oe_o),
    .bit_cnt_o    (bit_cnt)
  );

  sri_regs #(.REG_W(REG_W), .ADDR_W(ADDR_W), .GAIN_W(GAIN_W), .NUM_COL(NUM_COL)) u_regs (
    .clk_i, .rst_ni,
    .wr_en_i      (wr_en),
    .wr_addr_i    (wr_addr),
    .wr_data_i    (wr_data),
    .rd_addr_i    (rd_addr),
    .rd_data_o    (rd_data),
    .cfg_flags_o  (cfg_flags),
    .rgb_order_o  (mux_rgb_order_o),
    .single_sel_o (mux_single_sel_o),
    .clamp_code_o (clamp_code_o),
    .gain_o       (gain_o),
    .offset_o     (offset_o)
  );

  assign {cfg_clamp_int_o, cfg_three_ch_o, cfg_cds_o,
          cfg_pwr_dn_o, cfg_range_2v_o, cfg_byte_out_o} = cfg_flags;
endmodule

// File: rtl/sri_chk.sv
module sri_chk #(
  parameter int CNT_W = 4,
  parameter int GW    = 18,
  parameter int OW    = 27
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sload_lvl_i,
  input logic             wr_en_i,
  input logic             oe_i,
  input logic [CNT_W-1:0] bit_cnt_i,
  input logic             pwr_dn_i,
  input logic [8:0]       mux_fields_i,
  input logic [GW-1:0]    gain_i,
  input logic [OW-1:0]    offset_i
);
  assert_oe_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sload_lvl_i |=> !oe_i);

  assert_oe_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_i) |-> bit_cnt_i == CNT_W'(4));

  assert_wr_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !wr_en_i);

  assert_wr_full_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> $past(bit_cnt_i) == CNT_W'(13));

  assert_no_wr_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_i |-> !wr_en_i);

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(gain_i) && $stable(offset_i) && $stable(mux_fields_i));

  assert_pd_keep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_dn_i) |-> $stable(gain_i) && $stable(offset_i) && $stable(mux_fields_i));
endmodule

bind ser_reg_if sri_chk #(.CNT_W(CNT_W), .GW(NUM_COL*GAIN_W), .OW(NUM_COL*REG_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sload_lvl_i  (sload_lvl),
  .wr_en_i      (wr_en),
  .oe_i         (sdata_oe_o),
  .bit_cnt_i    (bit_cnt),
  .pwr_dn_i     (cfg_pwr_dn_o),
  .mux_fields_i ({mux_rgb_order_o, mux_single_sel_o, clamp_code_o, 1'b0}),
  .gain_i       (gain_o),
  .offset_i     (offset_o)
);

// File: tb/ser_reg_if_tb_top.sv
module ser_reg_if_tb_top;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, sload_n = 1'b1, sdata = 1'b0;
  logic sdo, sdo_oe;
  logic clamp_int, three_ch, cds, pwr_dn, range_2v, byte_out, rgb_order;
  logic [2:0] single_sel;
  logic [3:0] clamp_code;
  logic [17:0] gain;
  logic [26:0] offset;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  logic [8:0] rd_val;
  bit oe_bad;

  always #4 clk = ~clk;

  ser_reg_if dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sload_ni(sload_n), .sdata_i(sdata),
    .sdata_o(sdo), .sdata_oe_o(sdo_oe),
    .cfg_clamp_int_o(clamp_int), .cfg_three_ch_o(three_ch), .cfg_cds_o(cds),
    .cfg_pwr_dn_o(pwr_dn), .cfg_range_2v_o(range_2v), .cfg_byte_out_o(byte_out),
    .mux_rgb_order_o(rgb_order), .mux_single_sel_o(single_sel), .clamp_code_o(clamp_code),
    .gain_o(gain), .offset_o(offset)
  );

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Ends right after the strobe is released.
  task automatic frame(input logic rw, input logic [2:0] a, input logic [8:0] d, input int nbits);
    logic [12:0] bits;
    bits = {rw, a, d};
    rd_val = '0;
    oe_bad = 1'b0;
    wclk(1);
    sload_n = 1'b0;
    wclk(HALF);
    for (int i = 0; i < nbits; i++) begin
      sdata = (i < 13) ? bits[12-i] : 1'b0;
      wclk(HALF);
      if (rw && i >= 4 && i < 13) begin
        rd_val[12-i] = sdo;
        if (!sdo_oe) oe_bad = 1'b1;
      end
      if (i < 4 && sdo_oe) oe_bad = 1'b1;
      sclk = 1'b1;
      wclk(HALF);
      sclk = 1'b0;
    end
    wclk(HALF);
    sload_n = 1'b1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [8:0] d);
    frame(1'b0, a, d, 13);
    wclk(HALF);
  endtask

  task automatic rd(input logic [2:0] a);
    frame(1'b1, a, 9'h000, 13);
    wclk(HALF);
  endtask

  task automatic t_reset;
    logic [8:0] exp_rst [8];
    exp_rst = '{9'h070, 9'h0CF, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0};
    chk("R1 cfg fields", {clamp_int, three_ch, cds, pwr_dn, range_2v, byte_out}, 6'b111000);
    chk("R1 mux fields", {rgb_order, single_sel, clamp_code}, 8'b1_100_1111);
    chk("R1 gain", gain, 0);
    chk("R1 offset", offset, 0);
    chk("R5 oe idle", sdo_oe, 0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a));
      chk("R1 R6 readback", rd_val, exp_rst[a]);
    end
  endtask

  task automatic t_write_all;
    logic [8:0] v [8];
    v = '{9'h02B, 9'h135, 9'h1E5, 9'h03F, 9'h0C1, 9'h1FF, 9'h100, 9'h0AA};
    for (int a = 0; a < 8; a++) wr(3'(a), v[a]);
    chk("R3 cfg fields", {clamp_int, three_ch, cds, pwr_dn, range_2v, byte_out}, 6'b010011);
    chk("R3 mux fields", {rgb_order, single_sel, clamp_code}, 8'b0_011_0101);
    chk("R3 gain", gain, {6'h01, 6'h3F, 6'h25});
    chk("R3 offset", offset, {9'h0AA, 9'h100, 9'h1FF});
    for (int a = 0; a < 8; a++) begin
      rd(3'(a));
      chk("R2 R6 readback", rd_val, v[a]);
      chk("R5 oe window", oe_bad, 0);
    end
  endtask

  task automatic t_latency;
    frame(1'b0, 3'd3, 9'h012, 13);
    wclk(3);
    chk("R10 not yet", gain[11:6], 6'h3F);
    wclk(1);
    chk("R10 updated", gain[11:6], 6'h12);
    wclk(HALF);
    chk("R5 oe low after", sdo_oe, 0);
  endtask

  task automatic t_bad_len;
    frame(1'b0, 3'd7, 9'h055, 12);
    wclk(HALF);
    chk("R4 short frame", offset[26:18], 9'h0AA);
    frame(1'b0, 3'd7, 9'h055, 14);
    wclk(HALF);
    chk("R4 long frame", offset[26:18], 9'h0AA);
    rd(3'd7);
    chk("R4 readback", rd_val, 9'h0AA);
  endtask

  task automatic t_idle_clk;
    bit oe_seen = 1'b0;
    for (int i = 0; i < 13; i++) begin
      sdata = i[0];
      wclk(HALF);
      sclk = 1'b1;
      wclk(HALF);
      sclk = 1'b0;
      if (sdo_oe) oe_seen = 1'b1;
    end
    wclk(HALF);
    chk("R9 oe quiet", oe_seen, 0);
    chk("R9 gain held", gain, {6'h01, 6'h12, 6'h25});
    chk("R9 offset held", offset, {9'h0AA, 9'h100, 9'h1FF});
  endtask

  task automatic t_read_hold;
    logic [17:0] g0;
    logic [26:0] o0;
    g0 = gain;
    o0 = offset;
    frame(1'b1, 3'd5, 9'h000, 13);
    wclk(HALF);
    chk("R7 gain", gain, g0);
    chk("R7 offset", offset, o0);
    chk("R7 value", rd_val, 9'h1FF);
  endtask

  task automatic t_power_down;
    wr(3'd0, 9'h074);
    chk("R8 pwr_dn set", pwr_dn, 1);
    chk("R8 mux kept", {rgb_order, single_sel, clamp_code}, 8'b0_011_0101);
    chk("R8 gain kept", gain, {6'h01, 6'h12, 6'h25});
    rd(3'd6);
    chk("R8 offset kept", rd_val, 9'h100);
    wr(3'd0, 9'h070);
    chk("R8 pwr_dn clear", pwr_dn, 0);
  endtask

  initial begin
    wclk(3);
    rst_n = 1'b1;
    wclk(4);
    t_reset();
    t_write_all();
    t_latency();
    t_bad_len();
    t_idle_clk();
    t_read_hold();
    t_power_down();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule